// File: doc/BRIEF.md
# Clock Timer with Latched Readout

This block is a free-running eight-stage binary divider. It is clocked by a 32.768 kHz clock. A prescaler inside the block turns that clock into a one-cycle enable at 256 Hz. Each enable advances the divider by one while the timer runs, so the eight count bits carry taps from 128 Hz down to 1 Hz. Software sees the block through a 4-bit register window. The window holds a control register with a run bit and a self-clearing clear bit, the count split into two read-only nibbles, an interrupt mask nibble and an interrupt flag nibble.

Four of the taps are event sources: 32 Hz, 8 Hz, 2 Hz and 1 Hz. Each source sets a sticky flag when its tap completes a period. A single interrupt request is raised while any flag is set together with its mask bit. Software clears a flag by writing 1 to it.

The count is read as two nibbles, and the divider may advance between the two reads. To keep the pair consistent, a read of the low nibble freezes a copy of the high nibble. The copy is released when the high nibble is read or after 32 clock cycles, whichever comes first.

The register port is a plain single-cycle strobe interface with no back-pressure. A write takes effect at the clock edge where `wr_en` is high. `rd_data` always shows the register chosen by `reg_addr`, combinationally. `rd_en` only marks the cycle in which software takes the value, which matters for the readout latch.

Top module: `clk_tmr`

## Requirements
- R1: After `rst_n` is released, every register (addresses 0 to 4) reads 0 and `irq` is 0.
- R2: Address 0 is the control register. Bit 0 is run (1 = run, 0 = stop) and reads back as written. Bits 3 to 1 always read 0.
- R3: The prescaler gives one enable every 128 clock cycles. It keeps running while the timer is stopped. The 8-bit count grows by one on each enable only while run is 1; while run is 0 it holds its value.
- R4: A write to address 0 with bit 1 set clears both the prescaler and the count at that edge. The run bit is taken from bit 0 of the same write. After the clear, the count stays 0 while stopped, or counts again from 0 while running. A write with bit 1 = 0 clears nothing.
- R5: Address 1 returns count bits 3:0 (bit 0 = 128 Hz, bit 3 = 16 Hz). Address 2 returns count bits 7:4 (bit 0 = 8 Hz, bit 3 = 1 Hz) when no copy is held. Writes to addresses 1 and 2 have no effect.
- R6: A read strobe on address 1 stores count bits 7:4 and starts a 32-cycle hold. During the hold, address 2 returns the stored value. The hold ends on a read strobe of address 2 or when the 32 cycles expire. A new address-1 read during the hold refreshes the copy and restarts the hold.
- R7: Address 4 holds the flags. Bit 0 is 32 Hz (count bit 2), bit 1 is 8 Hz (count bit 4), bit 2 is 2 Hz (count bit 6) and bit 3 is 1 Hz (count bit 7). A flag is set when the count advances and its tap bit falls from 1 to 0. It is set whatever the mask bit holds. A clear does not set any flag.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, it stays set.
- R9: Address 3 holds the mask, with the same bit order as the flags (1 = enabled). `irq` is high exactly when some flag bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register select, 0 to 4 |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 4 | Write data |
| rd_en | input | 1 | Read strobe; has side effects on addresses 1 and 2 |
| rd_data | output | 4 | Contents of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler phase or a missed count enable changes the low count nibble within 128 cycles. From then on every read of address 1 disagrees with the expected value. A fault in the readout latch shows as address 2 returning either the live nibble or a stale copy. This is exposed by reads placed a few cycles before, and after, the 32-cycle hold ends, on either side of a high-nibble change. A wrong flag tap or a wrong set-versus-clear priority shows in the flag register and on `irq` one cycle after the event edge. The slowest case is the 1 Hz source, which needs 32768 cycles of uninterrupted running.

// File: rtl/clk_tmr_pkg.sv
package clk_tmr_pkg;
  localparam int NIB = 4;
  localparam int CNT_W = 2 * NIB;

  typedef enum logic [2:0] {
    ADDR_CTRL = 3'd0,
    ADDR_DLO  = 3'd1,
    ADDR_DHI  = 3'd2,
    ADDR_MASK = 3'd3,
    ADDR_FLAG = 3'd4
  } reg_addr_e;

  // count bit that feeds each flag position (32, 8, 2, 1 Hz)
  function automatic int tap_bit(input int idx);
    case (idx)
      0: tap_bit = 2;
      1: tap_bit = 4;
      2: tap_bit = 6;
      default: tap_bit = 7;
    endcase
  endfunction
endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clr||tick) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/ct_divider.sv
module ct_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic         tick,
  output logic         adv,
  output logic [W-1:0] cnt
);
  assign adv = tick && run && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (adv) cnt <= cnt + 1'b1;
  end

  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt));
  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/ct_read_latch.sv
module ct_read_latch #(
  parameter int W    = 4,
  parameter int HOLD = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic         rel,
  input  logic [W-1:0] live_hi,
  output logic [W-1:0] hi_rd
);
  localparam int HW = (HOLD > 2) ? $clog2(HOLD) : 1;
  localparam logic [HW-1:0] HLAST = HW'(HOLD - 1);

  logic          held_q;
  logic [W-1:0]  copy_q;
  logic [HW-1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      copy_q <= '0;
      age_q  <= '0;
    end else if (cap) begin
      held_q <= 1'b1;
      copy_q <= live_hi;
      age_q  <= '0;
    end else if (held_q) begin
      if (rel || age_q == HLAST) held_q <= 1'b0;
      else                       age_q  <= age_q + 1'b1;
    end
  end

  assign hi_rd = held_q ? copy_q : live_hi;

  // R6
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (held_q && hi_rd == $past(live_hi)));
  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && !cap && held_q) |=> !held_q);
endmodule

// File: rtl/ct_irq_unit.sv
module ct_irq_unit
  import clk_tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wr_mask,
  input  logic             wr_flag,
  input  logic [NIB-1:0]   wdata,
  output logic [NIB-1:0]   flags,
  output logic [NIB-1:0]   mask,
  output logic             irq
);
  logic [NIB-1:0] evt;
  logic [NIB-1:0] clr_bits;

  // a tap falls when the carry of this advance runs through it
  for (genvar i = 0; i < NIB; i++) begin : g_evt
    localparam int TB = tap_bit(i);
    assign evt[i] = adv && (&cnt[TB:0]);
  end

  assign clr_bits = wr_flag ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= (flags & ~clr_bits) | evt;
      if (wr_mask) mask <= wdata;
    end
  end

  assign irq = |(flags & mask);

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits != '0) |=> ((flags & $past(clr_bits & ~evt)) == '0));
endmodule

// File: rtl/clk_tmr.sv
module clk_tmr
  import clk_tmr_pkg::*;
#(
  parameter int PRE_DIV  = 128,
  parameter int HOLD_CYC = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  input  logic       rd_en,
  output logic [3:0] rd_data,
  output logic       irq
);
  logic             run_q;
  logic             tick;
  logic             adv;
  logic             tmr_clr;
  logic [CNT_W-1:0] cnt;
  logic [NIB-1:0]   hi_rd;
  logic [NIB-1:0]   flags;
  logic [NIB-1:0]   mask;
  logic             wr_ctrl;

  assign wr_ctrl = wr_en && (reg_addr == ADDR_CTRL);
  assign tmr_clr = wr_ctrl && wr_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= 1'b0;
    else if (wr_ctrl) run_q <= wr_data[0];
  end

  ct_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick)
  );

  ct_divider #(.W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(run_q),
    .tick(tick), .adv(adv), .cnt(cnt)
  );

  ct_read_latch #(.W(NIB), .HOLD(HOLD_CYC)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .cap(rd_en && reg_addr == ADDR_DLO),
    .rel(rd_en && reg_addr == ADDR_DHI),
    .live_hi(cnt[CNT_W-1:NIB]), .hi_rd(hi_rd)
  );

  ct_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .adv(adv), .cnt(cnt),
    .wr_mask(wr_en && reg_addr == ADDR_MASK),
    .wr_flag(wr_en && reg_addr == ADDR_FLAG),
    .wdata(wr_data), .flags(flags), .mask(mask), .irq(irq)
  );

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: rd_data = {3'b000, run_q};
      ADDR_DLO:  rd_data = cnt[NIB-1:0];
      ADDR_DHI:  rd_data = hi_rd;
      ADDR_MASK: rd_data = mask;
      ADDR_FLAG: rd_data = flags;
      default:   rd_data = '0;
    endcase
  end

  // R2
  run_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (run_q == $past(wr_data[0])));
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

// File: tb/clk_tmr_tb_top.sv
module clk_tmr_tb_top;
  localparam int CLK_PERIOD = 30;
  localparam int PRE_DIV = 128;
  localparam int HOLD_CYC = 32;

  logic clk = 0, rst_n = 0;
  logic [2:0] reg_addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [3:0] wr_data = 0;
  logic [3:0] rd_data;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_tmr #(.PRE_DIV(PRE_DIV), .HOLD_CYC(HOLD_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  // reference model built from the requirements
  int m_pre, m_hc;
  logic [7:0] m_cnt;
  logic m_run, m_hold;
  logic [3:0] m_flags, m_mask, m_held;

  function automatic logic [3:0] events(logic [7:0] c, bit a);
    logic [3:0] e;
    e[0] = a && (&c[2:0]);
    e[1] = a && (&c[4:0]);
    e[2] = a && (&c[6:0]);
    e[3] = a && (&c[7:0]);
    return e;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= 0; m_cnt <= 0; m_run <= 0; m_hold <= 0; m_hc <= 0;
      m_flags <= 0; m_mask <= 0; m_held <= 0;
    end else begin
      bit tk, clr, a;
      tk  = (m_pre == PRE_DIV - 1);
      clr = wr_en && reg_addr == 0 && wr_data[1];
      a   = tk && m_run && !clr;
      if (wr_en && reg_addr == 0) m_run <= wr_data[0];
      m_pre <= (clr || tk) ? 0 : m_pre + 1;
      if (clr) m_cnt <= 0; else if (a) m_cnt <= m_cnt + 1;
      m_flags <= (m_flags & ~((wr_en && reg_addr == 4) ? wr_data : 4'h0))
                 | events(m_cnt, a);
      if (wr_en && reg_addr == 3) m_mask <= wr_data;
      if (rd_en && reg_addr == 1) begin
        m_hold <= 1; m_held <= m_cnt[7:4]; m_hc <= 0;
      end else if (m_hold) begin
        if ((rd_en && reg_addr == 2) || m_hc == HOLD_CYC - 1) m_hold <= 0;
        else m_hc <= m_hc + 1;
      end
    end
  end

  function automatic logic [3:0] exp_rd(logic [2:0] a);
    case (a)
      0: return {3'b000, m_run};
      1: return m_cnt[3:0];
      2: return m_hold ? m_held : m_cnt[7:4];
      3: return m_mask;
      4: return m_flags;
      default: return 4'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit w, bit r, logic [2:0] a, logic [3:0] d);
    string req;
    @(negedge clk);
    wr_en = w; rd_en = r; reg_addr = a; wr_data = d;
    #1;
    case (a)
      0: req = "R2";
      1: req = "R5";
      2: req = m_hold ? "R6" : "R5";
      3: req = "R9";
      default: req = "R7";
    endcase
    chk(req, rd_data, exp_rd(a));
    chk("R9", {3'b0, irq}, {3'b0, |(m_flags & m_mask)});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 3'($urandom_range(0, 4)), 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [3:0] v0, old_hi;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      step(0, 0, 3'(a), 0);
      chk("R1", rd_data, 4'h0);
      chk("R1", {3'b0, irq}, 4'h0);
    end
    // R2 run bit readback, upper bits read zero
    step(1, 0, 0, 4'hD);
    step(0, 0, 0, 0);
    chk("R2", rd_data, 4'h1);
    // R5 writes to data nibbles ignored
    step(1, 0, 1, 4'hF);
    step(1, 0, 2, 4'hF);
    step(0, 0, 1, 0);
    chk("R5", rd_data, m_cnt[3:0]);
    idle(600);
    // R3 stop holds count
    step(1, 0, 0, 4'h0);
    step(0, 0, 1, 0);
    v0 = rd_data;
    idle(400);
    step(0, 0, 1, 0);
    chk("R3", rd_data, v0);
    // R4 clear while stopped stays zero
    step(1, 0, 0, 4'h2);
    idle(300);
    step(0, 0, 1, 0);
    chk("R4", rd_data, 4'h0);
    step(0, 0, 2, 0);
    chk("R4", rd_data, 4'h0);
    step(1, 0, 0, 4'h1);
    idle(PRE_DIV * 3 + 5);
    step(0, 0, 1, 0);
    chk("R4", rd_data, 4'h3);
    // R6 held copy returned across a high-nibble change
    while (!(m_cnt[3:0] == 4'hF && m_pre == 99)) step(0, 0, 0, 0);
    old_hi = m_cnt[7:4];
    step(0, 1, 1, 0);
    idle(29);
    step(0, 1, 2, 0);
    chk("R6", rd_data, old_hi);
    step(0, 0, 2, 0);
    chk("R6", rd_data, old_hi + 4'h1);
    // R6 timeout releases the copy
    while (!(m_cnt[3:0] == 4'hF && m_pre == 99)) step(0, 0, 0, 0);
    old_hi = m_cnt[7:4];
    step(0, 1, 1, 0);
    idle(40);
    step(0, 0, 2, 0);
    chk("R6", rd_data, old_hi + 4'h1);
    // R8 set wins over same-cycle clear
    while (!(m_pre == PRE_DIV - 2 && m_cnt[2:0] == 3'h7)) step(0, 0, 0, 0);
    step(1, 0, 4, 4'hF);
    step(0, 0, 4, 0);
    chk("R8", {3'b0, rd_data[0]}, 4'h1);
    step(1, 0, 4, 4'h1);
    step(0, 0, 4, 0);
    chk("R8", {3'b0, rd_data[0]}, 4'h0);
    // R9 mask enables irq
    step(1, 0, 3, 4'hF);
    // random phase, no control writes: reaches the 1 Hz event (R7)
    for (int i = 0; i < 34000; i++) begin
      int p = $urandom_range(0, 999);
      if (p < 5)       step(1, 0, 4, 4'($urandom));
      else if (p < 8)  step(1, 0, 3, 4'($urandom));
      else if (p < 12) step(1, 0, 3'($urandom_range(1, 2)), 4'($urandom));
      else             step(0, ($urandom_range(0, 3) == 0), 3'($urandom_range(0, 4)), 0);
    end
    // random phase with occasional control writes
    for (int i = 0; i < 40000; i++) begin
      int p = $urandom_range(0, 2999);
      if (p == 0)       step(1, 0, 0, 4'($urandom));
      else if (p < 3)   step(1, 0, 0, 4'h1);
      else if (p < 15)  step(1, 0, 4, 4'($urandom));
      else if (p < 25)  step(1, 0, 3, 4'($urandom));
      else              step(0, ($urandom_range(0, 3) == 0), 3'($urandom_range(0, 4)), 0);
    end
    finish_run();
  end
endmodule